// File: doc/BRIEF.md
# Streaming Monobit and Runs Statistics

This block watches a serial bit stream, one bit per cycle when its strobe is high. It gathers the integer statistics that two standard randomness checks need: the balance of ones against zeros, and the number of runs of identical bits. A block of n bits is opened by a start request, which also carries n. When the n-th accepted bit has been counted, the block reports five results: the count of ones, the count of zeros, the signed sum (+1 for each one, −1 for each zero), the total number of runs, and a verdict on whether the ones proportion is close enough to one half for the runs statistic to be meaningful.

The proportion verdict uses integer arithmetic only. For n bits with `ones` ones, the requirement |ones/n − ½| < 2/√n is rewritten as (2·ones − n)² < 16·n, so no division or square root is needed. A block of fewer than 100 bits is too short for the runs statistic. In that case a separate flag is raised and the verdict stays low. Any P-value or error-function computation is left to downstream software.

Top module: `seq_stat_engine`

## Requirements
- R1: After reset, done_o, runs_ok_o and too_short_o are 0, and ones_o, zeros_o, sum_o and runs_o are 0.
- R2: start_i latches len_i as n and clears all results. A bit presented in the same cycle as start_i, or while no block is open, is not counted.
- R3: Each accepted bit of value 1 adds 1 to ones_o, and each accepted 0 adds 1 to zeros_o. sum_o is the two's-complement value ones_o − zeros_o, LEN_W+2 bits wide.
- R4: runs_o is 1 plus the number of adjacent accepted bit pairs that differ. It is 0 before the first accepted bit.
- R5: done_o is high for exactly one cycle, starting on the clock edge after the edge that accepts the n-th bit. All results hold until the next start_i.
- R6: runs_ok_o is 1 exactly when n ≥ 100 and (2·ones − n)² < 16·n. A result of exactly 16·n gives 0.
- R7: too_short_o is 1 exactly when n < 100. runs_ok_o is then 0.
- R8: A start_i during an open block abandons that block. Counting begins afresh with the next accepted bit, under the new n.
- R9: A start_i with len_i = 0 pulses done_o on the second edge after the start, with all counts 0 and too_short_o = 1.
- R10: Cycles with bit_valid_i low do not change any result, whatever bit_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Clear results and open a new block |
| len_i | input | LEN_W | Block length n, sampled with start_i |
| bit_valid_i | input | 1 | Strobe marking bit_i as a stream bit |
| bit_i | input | 1 | Stream bit |
| done_o | output | 1 | One-cycle pulse when results are final |
| ones_o | output | LEN_W | Count of accepted ones |
| zeros_o | output | LEN_W | Count of accepted zeros |
| sum_o | output | LEN_W+2 | Signed sum of ±1 per bit |
| runs_o | output | LEN_W | Total number of runs |
| runs_ok_o | output | 1 | Proportion prerequisite for the runs statistic holds |
| too_short_o | output | 1 | Block shorter than the minimum length |

## Verification
The assertions assume the following about the inputs:
- bit_i is a known value in every cycle where bit_valid_i is high.
- start_i is a level sampled once per edge.
- The latched length fits in LEN_W bits, so no counter can run past n.

The stimulus changes every input on the falling clock edge and keeps bit_i defined. Where bit_valid_i is low, bit_i deliberately holds the inverse of the adjacent stream bit. Block lengths are kept between 0 and 400, well inside the 16-bit length register.

// File: rtl/seq_stat_pkg.sv
package seq_stat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EVAL = 2'd2
  } stat_state_e;

endpackage

// File: rtl/seq_stat_ctrl.sv
module seq_stat_ctrl
  import seq_stat_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             clr_o,
  output logic             take_o,
  output logic             eval_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o
);

  stat_state_e      state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [LEN_W-1:0] len_q;
  logic             done_q, done_d;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    cnt_inc = cnt_q + 1'b1;
    if (start_i) begin
      cnt_d   = '0;
      state_d = (len_i == '0) ? ST_EVAL : ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (valid_i) begin
            cnt_d = cnt_inc;
            if (cnt_inc == len_q) state_d = ST_EVAL;
          end
        end
        ST_EVAL: begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      if (start_i) len_q <= len_i;
    end
  end

  assign clr_o  = start_i;
  assign take_o = (state_q == ST_RUN) && valid_i && !start_i;
  assign eval_o = (state_q == ST_EVAL) && !start_i;
  assign done_o = done_q;
  assign len_o  = len_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q < len_q));

endmodule

// File: rtl/seq_stat_accum.sv
module seq_stat_accum #(
  parameter int LEN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    take_i,
  input  logic                    bit_i,
  output logic [LEN_W-1:0]        ones_o,
  output logic [LEN_W-1:0]        zeros_o,
  output logic signed [LEN_W+1:0] sum_o,
  output logic [LEN_W-1:0]        runs_o
);

  localparam int SUM_W = LEN_W + 2;
  localparam logic signed [SUM_W-1:0] SUM_ONE = SUM_W'(1);

  logic [LEN_W-1:0]        ones_q, ones_d, zeros_q, zeros_d, runs_q, runs_d;
  logic signed [SUM_W-1:0] sum_q, sum_d;
  logic                    prev_q, prev_d, first_q, first_d;
  logic                    acc_en;
  logic [LEN_W:0]          total_w;

  assign acc_en = clr_i | take_i;

  // next state
  always_comb begin
    ones_d  = ones_q;
    zeros_d = zeros_q;
    sum_d   = sum_q;
    runs_d  = runs_q;
    prev_d  = prev_q;
    first_d = first_q;
    if (clr_i) begin
      ones_d  = '0;
      zeros_d = '0;
      sum_d   = '0;
      runs_d  = '0;
      prev_d  = 1'b0;
      first_d = 1'b1;
    end else if (take_i) begin
      if (bit_i) begin
        ones_d = ones_q + 1'b1;
        sum_d  = sum_q + SUM_ONE;
      end else begin
        zeros_d = zeros_q + 1'b1;
        sum_d   = sum_q - SUM_ONE;
      end
      if (first_q || (bit_i != prev_q)) runs_d = runs_q + 1'b1;
      prev_d  = bit_i;
      first_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= '0;
      zeros_q <= '0;
      sum_q   <= '0;
      runs_q  <= '0;
      prev_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (acc_en) begin
      ones_q  <= ones_d;
      zeros_q <= zeros_d;
      sum_q   <= sum_d;
      runs_q  <= runs_d;
      prev_q  <= prev_d;
      first_q <= first_d;
    end
  end

  assign ones_o  = ones_q;
  assign zeros_o = zeros_q;
  assign sum_o   = sum_q;
  assign runs_o  = runs_q;

  always_comb total_w = {1'b0, ones_q} + {1'b0, zeros_q};

  assert_sum_balance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q == ($signed({2'b00, ones_q}) - $signed({2'b00, zeros_q})));

  assert_runs_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, runs_q} <= total_w) && ((total_w == '0) || (runs_q != '0)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ones_q == '0) && (zeros_q == '0) && (runs_q == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !take_i) |=> $stable(ones_q) && $stable(zeros_q) && $stable(runs_q));

endmodule

// File: rtl/seq_stat_judge.sv
module seq_stat_judge #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             eval_i,
  input  logic [LEN_W-1:0] ones_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ok_o,
  output logic             short_o
);

  localparam int SUM_W = LEN_W + 2;
  localparam int SQ_W  = 2 * SUM_W;

  logic signed [SUM_W-1:0] dev_w;
  logic [SUM_W-1:0]        mag_w;
  logic [SQ_W-1:0]         sq_w, lim_w;
  logic                    within_w, short_w;
  logic                    ok_q, ok_d, short_q, short_d;

  // (2*ones - n)^2 < 16*n, no division
  always_comb begin
    dev_w    = $signed({1'b0, ones_i, 1'b0}) - $signed({2'b00, len_i});
    mag_w    = dev_w[SUM_W-1] ? $unsigned(-dev_w) : $unsigned(dev_w);
    sq_w     = SQ_W'(mag_w) * SQ_W'(mag_w);
    lim_w    = SQ_W'({len_i, 4'b0000});
    within_w = sq_w < lim_w;
  end

  generate
    if (MIN_LEN > 0) begin : g_minlen
      assign short_w = int'(len_i) < MIN_LEN;
    end else begin : g_nominlen
      assign short_w = 1'b0;
    end
  endgenerate

  always_comb begin
    ok_d    = ok_q;
    short_d = short_q;
    if (clr_i) begin
      ok_d    = 1'b0;
      short_d = 1'b0;
    end else if (eval_i) begin
      ok_d    = within_w && !short_w;
      short_d = short_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      short_q <= 1'b0;
    end else if (clr_i || eval_i) begin
      ok_q    <= ok_d;
      short_q <= short_d;
    end
  end

  assign ok_o    = ok_q;
  assign short_o = short_q;

  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && short_q));

  assert_ok_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(eval_i));

endmodule

// File: rtl/seq_stat_engine.sv
module seq_stat_engine #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic                    bit_valid_i,
  input  logic                    bit_i,
  output logic                    done_o,
  output logic [LEN_W-1:0]        ones_o,
  output logic [LEN_W-1:0]        zeros_o,
  output logic signed [LEN_W+1:0] sum_o,
  output logic [LEN_W-1:0]        runs_o,
  output logic                    runs_ok_o,
  output logic                    too_short_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             clr_w, take_w, eval_w;
  logic [LEN_W-1:0] len_w;

  // async assert, sync release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_stat_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .valid_i (bit_valid_i),
    .len_i   (len_i),
    .clr_o   (clr_w),
    .take_o  (take_w),
    .eval_o  (eval_w),
    .done_o  (done_o),
    .len_o   (len_w)
  );

  seq_stat_accum #(.LEN_W(LEN_W)) accum_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (clr_w),
    .take_i  (take_w),
    .bit_i   (bit_i),
    .ones_o  (ones_o),
    .zeros_o (zeros_o),
    .sum_o   (sum_o),
    .runs_o  (runs_o)
  );

  seq_stat_judge #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) judge_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (clr_w),
    .eval_i  (eval_w),
    .ones_i  (ones_o),
    .len_i   (len_w),
    .ok_o    (runs_ok_o),
    .short_o (too_short_o)
  );

endmodule

// File: tb/seq_stat_engine_tb_top.sv
module seq_stat_engine_tb_top;

  localparam int LEN_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i, bit_valid_i, bit_i;
  logic [LEN_W-1:0]  len_i;
  logic              done_o, runs_ok_o, too_short_o;
  logic [LEN_W-1:0]  ones_o, zeros_o, runs_o;
  logic signed [LEN_W+1:0] sum_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  seq_stat_engine #(.LEN_W(LEN_W), .MIN_LEN(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .bit_valid_i(bit_valid_i), .bit_i(bit_i), .done_o(done_o),
    .ones_o(ones_o), .zeros_o(zeros_o), .sum_o(sum_o), .runs_o(runs_o),
    .runs_ok_o(runs_ok_o), .too_short_o(too_short_o)
  );

  // kind 0: k ones then zeros; kind 1: k ones, k zeros, repeating
  typedef struct packed {
    int len; int kind; int k;
    int ones; int zeros; int sum; int runs; int ok; int shrt;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{100, 0, 100, 100,   0,  100,   1, 0, 0},
    '{100, 0,  69,  69,  31,   38,   2, 1, 0},
    '{100, 0,  70,  70,  30,   40,   2, 0, 0},
    '{100, 0,  31,  31,  69,  -38,   2, 1, 0},
    '{100, 0,  30,  30,  70,  -40,   2, 0, 0},
    '{100, 1,   1,  50,  50,    0, 100, 1, 0},
    '{120, 1,   2,  60,  60,    0,  60, 1, 0},
    '{ 99, 1,   1,  50,  49,    1,  99, 0, 1},
    '{ 10, 0,   0,   0,  10,  -10,   1, 0, 1},
    '{  1, 0,   1,   1,   0,    1,   1, 0, 1},
    '{400, 1,   3, 201, 199,    2, 134, 1, 0},
    '{256, 0, 160, 160,  96,   64,   2, 0, 0},
    '{256, 0, 159, 159,  97,   62,   2, 1, 0}
  };

  function automatic logic gen_bit(int kind, int k, int i);
    if (kind == 0) return (i < k);
    return ((i / k) % 2) == 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      summary();
    end
  end

  // opens a block, feeds it with gaps; returns at the negedge where done is high
  task automatic run_block(int len, int kind, int k);
    @(negedge clk);
    start_i = 1'b1; len_i = LEN_W'(len); bit_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i % 7 == 6) begin
        bit_valid_i = 1'b0;           // R10: gap with a misleading bit
        bit_i = ~gen_bit(kind, k, i);
        @(negedge clk);
      end
      bit_valid_i = 1'b1;
      bit_i = gen_bit(kind, k, i);
      @(negedge clk);
    end
    bit_valid_i = 1'b0;
    chk("R5", "done early", int'(done_o), 0);
    @(negedge clk);
    chk("R5", "done", int'(done_o), 1);
  endtask

  task automatic check_vec(vec_t v);
    chk("R3", "ones", int'(ones_o), v.ones);
    chk("R3", "zeros", int'(zeros_o), v.zeros);
    chk("R3", "sum", int'(sum_o), v.sum);
    chk("R4", "runs", int'(runs_o), v.runs);
    chk("R6", "runs_ok", int'(runs_ok_o), v.ok);
    chk("R7", "too_short", int'(too_short_o), v.shrt);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; bit_valid_i = 1'b0; bit_i = 1'b0; len_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "ones", int'(ones_o), 0);
    chk("R1", "zeros", int'(zeros_o), 0);
    chk("R1", "sum", int'(sum_o), 0);
    chk("R1", "runs", int'(runs_o), 0);
    chk("R1", "flags", int'({runs_ok_o, too_short_o}), 0);

    // table walk
    for (int t = 0; t < 13; t++) begin
      run_block(VEC[t].len, VEC[t].kind, VEC[t].k);
      check_vec(VEC[t]);
      @(negedge clk);
      chk("R5", "done single", int'(done_o), 0);
      check_vec(VEC[t]);               // R5: results hold
    end

    // R2: bits while no block is open are ignored
    bit_valid_i = 1'b1; bit_i = 1'b1;
    repeat (5) @(negedge clk);
    bit_valid_i = 1'b0;
    @(negedge clk);
    chk("R2", "idle ones", int'(ones_o), VEC[12].ones);
    chk("R2", "idle runs", int'(runs_o), VEC[12].runs);
    chk("R2", "idle done", int'(done_o), 0);

    // R2: bit in the start cycle is ignored
    start_i = 1'b1; len_i = 16'd2; bit_valid_i = 1'b1; bit_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; bit_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bit_valid_i = 1'b0;
    @(negedge clk);
    chk("R2", "done", int'(done_o), 1);
    chk("R2", "ones", int'(ones_o), 0);
    chk("R2", "zeros", int'(zeros_o), 2);
    chk("R2", "sum", int'(sum_o), -2);
    chk("R4", "runs", int'(runs_o), 1);
    chk("R7", "short", int'(too_short_o), 1);

    // R8: restart during an open block
    @(negedge clk);
    start_i = 1'b1; len_i = 16'd200;
    @(negedge clk);
    start_i = 1'b0; bit_valid_i = 1'b1; bit_i = 1'b1;
    repeat (50) @(negedge clk);
    bit_valid_i = 1'b0;
    chk("R8", "partial ones", int'(ones_o), 50);
    run_block(VEC[1].len, VEC[1].kind, VEC[1].k);
    chk("R8", "ones", int'(ones_o), VEC[1].ones);
    chk("R8", "sum", int'(sum_o), VEC[1].sum);
    chk("R8", "runs", int'(runs_o), VEC[1].runs);
    chk("R8", "ok", int'(runs_ok_o), VEC[1].ok);

    // R9: zero length
    @(negedge clk);
    start_i = 1'b1; len_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9", "done early", int'(done_o), 0);
    chk("R9", "cleared ones", int'(ones_o), 0);
    @(negedge clk);
    chk("R9", "done", int'(done_o), 1);
    chk("R9", "zeros", int'(zeros_o), 0);
    chk("R9", "runs", int'(runs_o), 0);
    chk("R9", "short", int'(too_short_o), 1);
    chk("R9", "ok", int'(runs_ok_o), 0);
    @(negedge clk);
    chk("R9", "done single", int'(done_o), 0);

    summary();
  end

endmodule